// File: doc/BRIEF.md
# Segmented Code Prefetch Unit

This block keeps a small stock of code bytes ready for the execute stage of a 16-bit processor that addresses memory in segments. It holds a code segment value and a fetch offset. From these it forms a 20-bit physical byte address and presents it on a simple request/ready memory port. Each byte the memory returns goes into a six-entry first-in first-out queue. While the queue has room, the unit keeps asking for the next byte.

The execute stage takes bytes one at a time from the head of the queue. When the program changes flow, the execute stage raises a flush together with a new segment and offset. The queue is then emptied, any byte that arrives in that same cycle is discarded, and fetching restarts at the new location.

A separate combinational port turns a segment and offset into a physical address for data accesses. The segment is chosen by a two-bit selector from the data, stack and extra segment values supplied at the ports, or from the current code segment.

Top module: `seg_prefetch_unit`

## Requirements
- R1: A physical address is the 16-bit segment value with four zero bits appended below it, plus the 16-bit offset. The sum is truncated to 20 bits, so any carry out of bit 19 is lost. `mem_addr_o` always carries the address formed from `fetch_cs_o` and `fetch_ip_o`.
- R2: While `rst` is high, and in the first cycle after it falls, the queue is empty, `q_count_o` is 0, `fetch_cs_o` equals `RESET_SEG` (default 16'hFFFF) and `fetch_ip_o` equals `RESET_OFF` (default 16'h0000).
- R3: `mem_req_o` is high exactly when the queue holds fewer than `DEPTH` (6) bytes, so no fetch is requested while the queue is full.
- R4: A byte is accepted in a cycle when `mem_req_o` and `mem_ready_i` are both high and `flush_i` is low. An accepted `mem_data_i` is appended to the queue, and `fetch_ip_o` then advances by one, wrapping from 16'hFFFF to 16'h0000 while `fetch_cs_o` stays the same.
- R5: Bytes leave the queue in the order they were accepted. Whenever the queue is not empty, `q_data_o` shows the oldest byte, and a high `pop_i` removes it at the clock edge.
- R6: A `pop_i` issued while the queue is empty has no effect: the count does not change and no byte is lost.
- R7: When a byte is accepted and another is popped in the same cycle, `q_count_o` is unchanged, and the new byte joins the tail behind the remaining bytes.
- R8: A cycle with `flush_i` high leaves the queue empty afterwards. It loads `fetch_cs_o` from `flush_seg_i` and `fetch_ip_o` from `flush_off_i`. A byte returned in that cycle and a pop requested in that cycle are both ignored.
- R9: `data_addr_o` is the R1 address of `data_off_i` in the segment chosen by `data_sel_i`: 0 selects `ds_i`, 1 selects `ss_i`, 2 selects `es_i`, and 3 selects the current `fetch_cs_o`. The output follows its inputs within the same cycle.
- R10: `q_empty_o` is high exactly when `q_count_o` is 0, and `q_full_o` is high exactly when `q_count_o` equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Discard queue and in-flight byte, reload fetch position |
| flush_seg_i | input | 16 | New code segment on flush |
| flush_off_i | input | 16 | New fetch offset on flush |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 20 | Physical address of the requested byte |
| mem_ready_i | input | 1 | Memory returns the requested byte this cycle |
| mem_data_i | input | 8 | Returned byte |
| pop_i | input | 1 | Execute side takes the head byte |
| q_data_o | output | 8 | Head byte of the queue |
| q_empty_o | output | 1 | Queue holds no bytes |
| q_full_o | output | 1 | Queue holds DEPTH bytes |
| q_count_o | output | $clog2(DEPTH+1) (3) | Bytes currently queued |
| fetch_cs_o | output | 16 | Current code segment |
| fetch_ip_o | output | 16 | Offset of the next byte to fetch |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| data_sel_i | input | 2 | Segment select for data address port |
| data_off_i | input | 16 | Offset for data address port |
| data_addr_o | output | 20 | Physical data address |

## Verification
The hardest case to reach is a flush that lands in the same cycle as a returned byte and a pop, while the queue is partly filled. A second hard case is a fetch offset that crosses 16'hFFFF inside a segment near the top of memory, where both the 16-bit wrap and the 20-bit wrap happen together. The stimulus reaches the first with a run of random ready, pop and flush decisions from a shift-register generator, with flushes aimed at mid-fill queue states. It reaches the second by flushing to segment 16'hFFFF, offset 16'hFFFC, and letting the queue fill across the boundary.

// File: rtl/seg_prefetch_pkg.sv
package seg_prefetch_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int PHYS_W = 20;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_STACK = 2'd1,
        SEL_EXTRA = 2'd2,
        SEL_CODE  = 2'd3
    } seg_sel_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } far_ptr_t;

    // segment * 16 + offset, carry beyond the top bit dropped
    function automatic logic [PHYS_W-1:0] to_phys(input far_ptr_t p);
        logic [PHYS_W-1:0] base;
        logic [PHYS_W-1:0] ext;
        base = {p.seg, 4'b0000};
        ext  = {{(PHYS_W-OFF_W){1'b0}}, p.off};
        return base + ext;
    endfunction

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_prefetch_pkg::*;
(
    input  far_ptr_t            ptr_i,
    output logic [PHYS_W-1:0]   phys_o
);
    always_comb phys_o = to_phys(ptr_i);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o,
    output logic             full_o
);
    logic [WIDTH-1:0] slots_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push_i && !full_o && !clear_i;
    assign do_pop  = pop_i && !empty_o && !clear_i;
    assign head_o  = slots_q[rd_q];
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots_q[wr_q] <= push_data_i;
    end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import seg_prefetch_pkg::*;
#(
    parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush_i,
    input  far_ptr_t flush_ptr_i,
    input  logic     room_i,
    input  logic     ready_i,
    output logic     req_o,
    output logic     accept_o,
    output far_ptr_t ptr_o
);
    far_ptr_t ptr_q;

    assign req_o    = room_i;
    assign accept_o = req_o && ready_i && !flush_i;
    assign ptr_o    = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q.seg <= RESET_SEG;
            ptr_q.off <= RESET_OFF;
        end else if (flush_i) begin
            ptr_q <= flush_ptr_i;
        end else if (accept_o) begin
            ptr_q.off <= ptr_q.off + OFF_W'(1);
        end
    end
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
    import seg_prefetch_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_OFF = 16'h0000,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic [15:0]       flush_seg_i,
    input  logic [15:0]       flush_off_i,
    output logic              mem_req_o,
    output logic [19:0]       mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [7:0]        mem_data_i,
    input  logic              pop_i,
    output logic [7:0]        q_data_o,
    output logic              q_empty_o,
    output logic              q_full_o,
    output logic [CNT_W-1:0]  q_count_o,
    output logic [15:0]       fetch_cs_o,
    output logic [15:0]       fetch_ip_o,
    input  logic [15:0]       ds_i,
    input  logic [15:0]       ss_i,
    input  logic [15:0]       es_i,
    input  logic [1:0]        data_sel_i,
    input  logic [15:0]       data_off_i,
    output logic [19:0]       data_addr_o
);
    far_ptr_t flush_ptr, code_ptr, data_ptr;
    logic     accept;

    assign flush_ptr.seg = flush_seg_i;
    assign flush_ptr.off = flush_off_i;

    fetch_sequencer #(
        .RESET_SEG (RESET_SEG),
        .RESET_OFF (RESET_OFF)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush_i),
        .flush_ptr_i (flush_ptr),
        .room_i      (!q_full_o),
        .ready_i     (mem_ready_i),
        .req_o       (mem_req_o),
        .accept_o    (accept),
        .ptr_o       (code_ptr)
    );

    prefetch_queue #(
        .DEPTH (DEPTH),
        .WIDTH (BYTE_W)
    ) u_queue (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (flush_i),
        .push_i      (accept),
        .push_data_i (mem_data_i),
        .pop_i       (pop_i),
        .head_o      (q_data_o),
        .count_o     (q_count_o),
        .empty_o     (q_empty_o),
        .full_o      (q_full_o)
    );

    seg_addr_gen u_code_addr (
        .ptr_i  (code_ptr),
        .phys_o (mem_addr_o)
    );

    always_comb begin
        data_ptr.off = data_off_i;
        unique case (seg_sel_e'(data_sel_i))
            SEL_DATA:  data_ptr.seg = ds_i;
            SEL_STACK: data_ptr.seg = ss_i;
            SEL_EXTRA: data_ptr.seg = es_i;
            default:   data_ptr.seg = code_ptr.seg;
        endcase
    end

    seg_addr_gen u_data_addr (
        .ptr_i  (data_ptr),
        .phys_o (data_addr_o)
    );

    assign fetch_cs_o = code_ptr.seg;
    assign fetch_ip_o = code_ptr.off;
endmodule

// File: rtl/seg_prefetch_chk.sv
module seg_prefetch_chk #(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_i,
    input logic [15:0]      flush_seg_i,
    input logic [15:0]      flush_off_i,
    input logic             mem_req_o,
    input logic [19:0]      mem_addr_o,
    input logic             mem_ready_i,
    input logic             pop_i,
    input logic             q_empty_o,
    input logic             q_full_o,
    input logic [CNT_W-1:0] q_count_o,
    input logic [15:0]      fetch_cs_o,
    input logic [15:0]      fetch_ip_o
);
    logic acc;
    assign acc = mem_req_o && mem_ready_i && !flush_i;

    // R3: no fetch request while the queue is full
    a_r3_no_req_when_full: assert property (@(posedge clk) disable iff (rst)
        q_full_o |-> !mem_req_o);

    // R3: the count never exceeds the queue depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(q_count_o) <= DEPTH);

    // R4: an accepted byte advances the offset by one inside the segment
    a_r4_ip_advance: assert property (@(posedge clk) disable iff (rst)
        acc |=> (fetch_ip_o == $past(fetch_ip_o) + 16'd1) && $stable(fetch_cs_o));

    // R6: a pop on an empty queue with nothing arriving leaves it empty
    a_r6_pop_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (q_empty_o && pop_i && !acc) |=> q_empty_o);

    // R7: push and pop together keep the count
    a_r7_push_pop_count: assert property (@(posedge clk) disable iff (rst)
        (acc && pop_i && !q_empty_o) |=> $stable(q_count_o));

    // R8: flush empties the queue and reloads the fetch position
    a_r8_flush_reload: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> q_empty_o && (fetch_cs_o == $past(flush_seg_i))
                    && (fetch_ip_o == $past(flush_off_i)));

    // R10: the flags agree with the count
    a_r10_flags: assert property (@(posedge clk) disable iff (rst)
        (q_empty_o == (q_count_o == '0)) && (q_full_o == (int'(q_count_o) == DEPTH)));

    // R1: the fetch address tracks the segment and offset
    a_r1_fetch_addr: assert property (@(posedge clk) disable iff (rst)
        mem_addr_o == ({fetch_cs_o, 4'b0000} + {4'b0000, fetch_ip_o}));
endmodule

bind seg_prefetch_unit seg_prefetch_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush_i     (flush_i),
    .flush_seg_i (flush_seg_i),
    .flush_off_i (flush_off_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .pop_i       (pop_i),
    .q_empty_o   (q_empty_o),
    .q_full_o    (q_full_o),
    .q_count_o   (q_count_o),
    .fetch_cs_o  (fetch_cs_o),
    .fetch_ip_o  (fetch_ip_o)
);

// File: tb/seg_prefetch_unit_tb.sv
module seg_prefetch_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 6;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush_i;
    logic [15:0] flush_seg_i, flush_off_i;
    logic        mem_req_o;
    logic [19:0] mem_addr_o;
    logic        mem_ready_i;
    logic [7:0]  mem_data_i;
    logic        pop_i;
    logic [7:0]  q_data_o;
    logic        q_empty_o, q_full_o;
    logic [2:0]  q_count_o;
    logic [15:0] fetch_cs_o, fetch_ip_o;
    logic [15:0] ds_i, ss_i, es_i;
    logic [1:0]  data_sel_i;
    logic [15:0] data_off_i;
    logic [19:0] data_addr_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_prefetch_unit u_dut (
        .clk(clk), .rst(rst), .flush_i(flush_i), .flush_seg_i(flush_seg_i),
        .flush_off_i(flush_off_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ready_i(mem_ready_i), .mem_data_i(mem_data_i), .pop_i(pop_i),
        .q_data_o(q_data_o), .q_empty_o(q_empty_o), .q_full_o(q_full_o),
        .q_count_o(q_count_o), .fetch_cs_o(fetch_cs_o), .fetch_ip_o(fetch_ip_o),
        .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i), .data_sel_i(data_sel_i),
        .data_off_i(data_off_i), .data_addr_o(data_addr_o)
    );

    // memory contents: a fixed function of the address
    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction
    assign mem_data_i = mem_byte(mem_addr_o);

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        int unsigned v;
        v = (int'(s) * 16 + int'(o)) % (1 << 20);
        return v[19:0];
    endfunction

    // reference model state
    logic [7:0]  mq[$];
    logic [15:0] m_cs, m_ip;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;
    logic [15:0] lfsr     = 16'hACE1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr;
    endfunction

    // one clock: drive at the falling edge, compare, advance the model
    task automatic cycle(input logic fl, input logic [15:0] fs, input logic [15:0] fo,
                         input logic pp, input logic rd);
        logic [15:0] sel_seg;
        logic        req_e, acc_e;
        flush_i = fl; flush_seg_i = fs; flush_off_i = fo;
        pop_i = pp; mem_ready_i = rd;
        data_sel_i = rnd()[1:0];
        data_off_i = rnd();
        #1;
        req_e = (mq.size() < DEPTH);
        check("R10 empty", 32'(q_empty_o), 32'(mq.size() == 0));
        check("R10 full",  32'(q_full_o),  32'(mq.size() == DEPTH));
        check("R5 count",  32'(q_count_o), 32'(mq.size()));
        check("R3 req",    32'(mem_req_o), 32'(req_e));
        check("R4 ip",     32'(fetch_ip_o), 32'(m_ip));
        check("R8 cs",     32'(fetch_cs_o), 32'(m_cs));
        check("R1 addr",   32'(mem_addr_o), 32'(phys(m_cs, m_ip)));
        if (mq.size() > 0) check("R5 head", 32'(q_data_o), 32'(mq[0]));
        case (data_sel_i)
            2'd0:    sel_seg = ds_i;
            2'd1:    sel_seg = ss_i;
            2'd2:    sel_seg = es_i;
            default: sel_seg = m_cs;
        endcase
        check("R9 data addr", 32'(data_addr_o), 32'(phys(sel_seg, data_off_i)));
        acc_e = req_e && rd;
        if (fl) begin
            mq.delete();
            m_cs = fs; m_ip = fo;
        end else begin
            if (pp && mq.size() > 0) void'(mq.pop_front());
            if (acc_e) begin
                mq.push_back(mem_byte(phys(m_cs, m_ip)));
                m_ip = m_ip + 16'd1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; flush_i = 0; flush_seg_i = 0; flush_off_i = 0;
        pop_i = 0; mem_ready_i = 0;
        ds_i = 16'h1234; ss_i = 16'h8000; es_i = 16'hFFFF;
        data_sel_i = 0; data_off_i = 0;
        m_cs = 16'hFFFF; m_ip = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        check("R2 empty", 32'(q_empty_o), 32'd1);
        check("R2 count", 32'(q_count_o), 32'd0);
        check("R2 cs",    32'(fetch_cs_o), 32'hFFFF);
        check("R2 ip",    32'(fetch_ip_o), 32'h0000);
        rst = 1'b0;
        // R3, R4, R10: fill to full with memory always ready, then hold
        for (int i = 0; i < 9; i++) cycle(0, 0, 0, 0, 1);
        // R5: drain in order with no new bytes
        for (int i = 0; i < 7; i++) cycle(0, 0, 0, 1, 0);
        // R6: pops on empty queue
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 1, 0);
        // R7: steady stream with pop and push each cycle
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) cycle(0, 0, 0, 1, 1);
        // R8: flush while a byte returns and a pop is requested
        cycle(1, 16'h0100, 16'h0020, 1, 1);
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 1);
        // R1, R4: offset and 20-bit wrap near the top of memory
        cycle(1, 16'hFFFF, 16'hFFFC, 0, 0);
        for (int i = 0; i < 10; i++) cycle(0, 0, 0, i > 6, 1);
        // random mix, including flushes at partial fill
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] r;
            r = rnd();
            cycle(r[4:0] == 5'd3, rnd(), rnd(), r[7], r[9] | r[10]);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule